// File: doc/BRIEF.md
# Downlink Test-Channel Slot Multiplexer

This block serialises one dedicated downlink test channel running at 30 ksps. Each slot is 40 bits long and a frame is 15 slots, or 600 bits. Every slot has the same layout, in this order:

- a 6-bit data field;
- a 2-bit power-control pair;
- an empty format-indicator field;
- a 24-bit data field;
- an 8-bit pilot field.

Data bits come from an external source through a request/bit handshake. The block makes the power-control and pilot bits itself. It emits one bit per clock-enable pulse, and marks the first bit of each slot and of each frame.

Frame timing is delayed after a start pulse by a programmable offset in units of 256 chips. At this symbol rate one unit equals 4 channel bits. At the first data position of every frame the block pulses a frame-sync line, so the data source can restart its sequence. Spreading, scrambling, power weighting and modulation happen downstream.

Top module: `dl_slot_mux`

## Requirements
- R1: While reset is asserted, and after release until a start is accepted, `tx_valid`, `data_req`, `frame_sync`, `slot_strobe` and `frame_strobe` are all 0.
- R2: After an accepted start, the first frame bit is produced on the (4·D+1)-th `bit_en` pulse that follows the start cycle. D is `offset` sampled in the start cycle, with values above 149 treated as 149.
- R3: A start pulse is ignored while the delay is counting or the channel is running. Neither the delay nor the bit sequence changes.
- R4: Each `tx_valid` pulse follows, one cycle later, a cycle in which `bit_en` was 1. There is no output without an enable.
- R5: Bit positions 0–5 and 8–31 of a slot are data positions, so there are 30 per slot and 450 per 600-bit frame. `data_req` is 1 only on enabled data positions.
- R6: At a data position, `tx_bit` equals the `data_bit` presented in the cycle in which `data_req` was 1.
- R7: Positions 6–7 carry the power-control pair. It is 00 in even slots, starting with slot 0, and 11 in odd slots.
- R8: Positions 32–33 and 36–37 are 1. Positions 34–35 carry a per-slot pair from the table 11,00,01,00,10,11,11,10,01,11,01,10,10,00,00. Positions 38–39 carry one from 10,10,01,00,01,10,00,00,10,11,01,11,00,11,11. Both tables are indexed by slot 0–14, and the left digit is sent first.
- R9: `slot_strobe` accompanies bit 0 of each slot and `frame_strobe` accompanies bit 0 of slot 0. `frame_sync` is 1 together with `data_req` for that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Channel-bit clock enable |
| start | input | 1 | Arms the frame-offset delay |
| offset | input | 8 | Frame offset in 256-chip units (0–149) |
| data_req | output | 1 | Requests one data bit this cycle |
| data_bit | input | 1 | Data bit answering `data_req` |
| frame_sync | output | 1 | First data request of a frame (source restart) |
| tx_valid | output | 1 | `tx_bit` is valid |
| tx_bit | output | 1 | Serial channel bit |
| slot_strobe | output | 1 | First bit of a slot |
| frame_strobe | output | 1 | First bit of a frame |

## Verification
The assertions watch several properties on every cycle:

- each output bit follows an enable;
- a requested data bit reaches `tx_bit` unchanged;
- `frame_strobe` implies `slot_strobe`, and `frame_sync` implies `data_req`;
- every slot is 40 bits and every frame is 15 slots.

The delay arithmetic, the offset clamp and the ignored start pulses show up only in the bench scenarios. The same holds for the exact power-control and pilot values per slot and the per-frame count of requests. The bench compares these with an independently built expected stream, under both steady and gapped enables.

// File: rtl/dl_slot_mux.sv
module dl_slot_mux #(
  parameter int OFF_W         = 8,
  parameter int MAX_OFFSET    = 149,
  parameter int BITS_PER_UNIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             start,
  input  logic [OFF_W-1:0] offset,
  output logic             data_req,
  input  logic             data_bit,
  output logic             frame_sync,
  output logic             tx_valid,
  output logic             tx_bit,
  output logic             slot_strobe,
  output logic             frame_strobe
);
  localparam int D1_N    = 6;
  localparam int TPC_N   = 2;
  localparam int TFCI_N  = 0;
  localparam int D2_N    = 24;
  localparam int PIL_N   = 8;
  localparam int SLOT_N  = D1_N + TPC_N + TFCI_N + D2_N + PIL_N;
  localparam int SLOTS   = 15;
  localparam int POS_W   = $clog2(SLOT_N);
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int WAIT_W  = $clog2(MAX_OFFSET * BITS_PER_UNIT + 1);

  localparam logic [POS_W-1:0]  TPC_LO    = POS_W'(D1_N);
  localparam logic [POS_W-1:0]  TFCI_LO   = POS_W'(D1_N + TPC_N);
  localparam logic [POS_W-1:0]  D2_LO     = TFCI_LO + POS_W'(TFCI_N);
  localparam logic [POS_W-1:0]  PIL_LO    = D2_LO + POS_W'(D2_N);
  localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(SLOT_N - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
  localparam logic [OFF_W-1:0]  OFF_MAX   = OFF_W'(MAX_OFFSET);

  // per-slot pilot pairs, slot 0 in the low two bits, first-sent bit is the upper one
  localparam logic [29:0] PIL_SYM1 = 30'b00_00_10_10_01_11_01_10_11_11_10_00_01_00_11;
  localparam logic [29:0] PIL_SYM3 = 30'b11_11_00_11_01_11_10_00_00_10_01_00_01_10_10;

  typedef enum logic [1:0] {IDLE, DELAY, RUN} state_t;

  state_t            st;
  logic [WAIT_W-1:0] wait_cnt;
  logic [POS_W-1:0]  pos;
  logic [SLOT_W-1:0] slot;
  logic              next_bit;
  logic              pilot_bit;

  wire [OFF_W-1:0]  off_eff   = (offset > OFF_MAX) ? OFF_MAX : offset;
  wire [WAIT_W-1:0] wait_load = WAIT_W'(off_eff) * WAIT_W'(BITS_PER_UNIT);

  wire active   = (st == RUN) || (st == DELAY && wait_cnt == '0);
  wire step     = bit_en && active;
  wire in_tpc   = (pos >= TPC_LO) && (pos < TFCI_LO);
  wire in_pilot = (pos >= PIL_LO);
  wire in_data  = (pos < TPC_LO) || ((pos >= D2_LO) && (pos < PIL_LO));
  wire [2:0] pidx = 3'(pos - PIL_LO);
  wire [1:0] pair1 = PIL_SYM1[{slot, 1'b0} +: 2];
  wire [1:0] pair3 = PIL_SYM3[{slot, 1'b0} +: 2];
  wire frame_first = (pos == '0) && (slot == '0);

  assign data_req   = step && in_data;
  assign frame_sync = step && frame_first;

  always_comb begin
    case (pidx[2:1])
      2'd1:    pilot_bit = pidx[0] ? pair1[0] : pair1[1];
      2'd3:    pilot_bit = pidx[0] ? pair3[0] : pair3[1];
      default: pilot_bit = 1'b1;
    endcase
    if (in_data)       next_bit = data_bit;
    else if (in_tpc)   next_bit = slot[0];
    else if (in_pilot) next_bit = pilot_bit;
    else               next_bit = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= IDLE;
      wait_cnt     <= '0;
      pos          <= '0;
      slot         <= '0;
      tx_valid     <= 1'b0;
      tx_bit       <= 1'b0;
      slot_strobe  <= 1'b0;
      frame_strobe <= 1'b0;
    end else begin
      tx_valid     <= step;
      slot_strobe  <= step && (pos == '0);
      frame_strobe <= step && frame_first;
      if (step) tx_bit <= next_bit;

      case (st)
        IDLE: if (start) begin
          st       <= DELAY;
          wait_cnt <= wait_load;
        end
        DELAY: if (bit_en) begin
          if (wait_cnt == '0) st <= RUN;
          else                wait_cnt <= wait_cnt - 1'b1;
        end
        default: ;
      endcase

      if (step) begin
        if (pos == LAST_POS) begin
          pos  <= '0;
          slot <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dl_slot_mux_chk.sv
module dl_slot_mux_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic data_req,
  input logic data_bit,
  input logic frame_sync,
  input logic tx_valid,
  input logic tx_bit,
  input logic slot_strobe,
  input logic frame_strobe
);
  logic [5:0] bits_in_slot;
  logic [3:0] slots_in_frame;
  logic       slot_seen, frame_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_in_slot   <= '0;
      slots_in_frame <= '0;
      slot_seen      <= 1'b0;
      frame_seen     <= 1'b0;
    end else if (tx_valid) begin
      if (slot_strobe) begin
        bits_in_slot <= 6'd1;
        slot_seen    <= 1'b1;
      end else begin
        bits_in_slot <= bits_in_slot + 1'b1;
      end
      if (frame_strobe) begin
        slots_in_frame <= 4'd1;
        frame_seen     <= 1'b1;
      end else if (slot_strobe) begin
        slots_in_frame <= slots_in_frame + 1'b1;
      end
    end
  end

  // R4
  bit_follows_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(bit_en));

  // R5
  req_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |-> bit_en);

  // R6
  data_passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |=> (tx_valid && tx_bit == $past(data_bit)));

  // R9
  frame_implies_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |-> (slot_strobe && tx_valid));

  // R9
  sync_is_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |-> data_req);

  // R5
  slot_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && slot_strobe && slot_seen) |-> bits_in_slot == 6'd40);

  // R5
  frame_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && frame_strobe && frame_seen) |-> slots_in_frame == 4'd15);
endmodule

bind dl_slot_mux dl_slot_mux_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .data_req(data_req),
  .data_bit(data_bit), .frame_sync(frame_sync), .tx_valid(tx_valid),
  .tx_bit(tx_bit), .slot_strobe(slot_strobe), .frame_strobe(frame_strobe)
);

// File: tb/sim_dl_slot_mux.sv
module sim_dl_slot_mux;
  logic       clk = 1'b0, rst_n = 1'b0, en_raw = 1'b0, start = 1'b0;
  logic [7:0] offset = 8'd0;
  logic       data_bit;
  wire        bit_en = en_raw & ~start;
  wire        data_req, frame_sync, tx_valid, tx_bit, slot_strobe, frame_strobe;

  always #2 clk = ~clk;

  dl_slot_mux u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start(start), .offset(offset),
    .data_req(data_req), .data_bit(data_bit), .frame_sync(frame_sync),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .slot_strobe(slot_strobe),
    .frame_strobe(frame_strobe)
  );

  int checks = 0, errors = 0;
  typedef struct { bit b; bit sf; bit ff; string tag; } item_t;
  item_t q[$];

  string SYM1 = "110001001011111001110110100000";
  string SYM3 = "101001000110000010110111001111";

  function automatic bit src_fn(input int k);
    return k[0] ^ k[3] ^ k[5] ^ (k % 3 == 0);
  endfunction

  int src_idx = 0;
  assign data_bit = frame_sync ? src_fn(0) : src_fn(src_idx);
  always @(posedge clk)
    if (!rst_n) src_idx <= 0;
    else if (data_req) src_idx <= frame_sync ? 1 : src_idx + 1;

  int gap_mode = 0;
  always @(negedge clk) en_raw <= (gap_mode != 0) ? ($urandom % 3 == 0) : 1'b1;

  int en_cnt = 0, req_cnt = 0, first_delay = 0, frames_seen = 0;
  bit prev_en = 1'b0, got_first = 1'b0;
  always @(posedge clk) begin
    if (bit_en) en_cnt++;
    if (data_req) req_cnt++;
    prev_en = bit_en;
  end

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && tx_valid && q.size() > 0) begin
      item_t x;
      chk(prev_en, 1, "R4 output without enable");
      if (!got_first) begin got_first = 1'b1; first_delay = en_cnt; end
      if (frame_strobe) begin
        if (frames_seen > 0) chk(req_cnt, 451, "R5 data requests per frame");
        frames_seen++;
        req_cnt = 1;
      end
      x = q.pop_front();
      chk(tx_bit, x.b, x.tag);
      chk(slot_strobe, x.sf, "R9 slot strobe");
      chk(frame_strobe, x.ff, "R9 frame strobe");
    end
  end

  function automatic item_t make_item(input int s, input int p, inout int k);
    item_t it;
    int pi;
    it.sf = (p == 0);
    it.ff = (p == 0) && (s == 0);
    if (p < 6 || (p >= 8 && p < 32)) begin
      it.b = src_fn(k); k++; it.tag = "R6 data bit";
    end else if (p < 8) begin
      it.b = s[0]; it.tag = "R7 power-control bit";
    end else begin
      pi = p - 32;
      it.tag = "R8 pilot bit";
      case (pi / 2)
        1:       it.b = (SYM1[s * 2 + pi % 2] == 8'h31);
        3:       it.b = (SYM3[s * 2 + pi % 2] == 8'h31);
        default: it.b = 1'b1;
      endcase
    end
    return it;
  endfunction

  task automatic run_case(input int off, input int frames, input int gap, input bit poke);
    int k, guard, eff;
    rst_n = 1'b0; gap_mode = gap;
    repeat (3) @(negedge clk);
    chk(tx_valid, 0, "R1 tx_valid in reset");
    chk(data_req | frame_sync, 0, "R1 request in reset");
    chk(slot_strobe | frame_strobe, 0, "R1 strobes in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_valid | data_req, 0, "R1 idle before start");
    q.delete();
    for (int f = 0; f < frames; f++) begin
      k = 0;
      for (int s = 0; s < 15; s++)
        for (int p = 0; p < 40; p++) q.push_back(make_item(s, p, k));
    end
    k = 0;
    q.push_back(make_item(0, 0, k));
    got_first = 1'b0; frames_seen = 0; req_cnt = 0;
    offset = off[7:0]; start = 1'b1; en_cnt = 0;
    @(negedge clk);
    start = 1'b0; offset = 8'd7;
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1; offset = 8'd0;   // R3 start during delay
      @(negedge clk);
      start = 1'b0;
      guard = 0;
      while (!got_first && guard < 20000) begin @(negedge clk); guard++; end
      repeat (50) @(negedge clk);
      start = 1'b1;                   // R3 start while running
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (q.size() > 0 && guard < 40000) begin @(negedge clk); guard++; end
    chk(q.size(), 0, "R2 stream completed");
    eff = (off > 149) ? 149 : off;
    chk(first_delay, eff * 4 + 1, poke ? "R3 delay after ignored start" : "R2 offset delay");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    run_case(3,   2, 0, 1'b0);
    run_case(0,   1, 1, 1'b0);
    run_case(200, 1, 0, 1'b1);
    run_case(149, 1, 1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule